// File: doc/BRIEF.md
# Three-Format Instruction Field Decoder

This block takes a 32-bit fixed-length instruction word and splits it into its fields. The 6-bit opcode at the top of the word selects one of three layouts. In the register layout, opcode zero is followed by three 5-bit register specifiers, a 5-bit shift amount and a 6-bit function code. In the immediate layout, two register specifiers are followed by a 16-bit constant. In the jump layout, a 26-bit target fills everything below the opcode.

The decoder returns the layout class and the fields that belong to that layout. Fields that do not belong to the layout are returned as zero. The decoder also builds a 32-bit immediate in one of three ways:
- sign extension, for the branches, add-immediate, load and store;
- zero extension, for or-immediate;
- placement in the upper half with the lower half cleared, for load-upper.

The all-zero word is flagged as a no-op. Opcodes outside the supported set are flagged as illegal, and their format outputs are cleared.

An instruction fetch stage uses the block by presenting one word per cycle with `in_valid` high. One cycle later the decoded fields appear with `out_valid` high. The output register loads only on cycles where `in_valid` is high, so it keeps its contents otherwise.

Top module: `instr_field_decoder`

## Requirements
- R1: With opcode 0 (bits 31:26), `out_fmt` is 1 (register). `out_rs`, `out_rt`, `out_rd`, `out_shamt` and `out_funct` carry word bits 25:21, 20:16, 15:11, 10:6 and 5:0. `out_imm` and `out_target` are 0.
- R2: Opcodes 4, 5, 8, 13, 15, 35 and 43 give `out_fmt` 2 (immediate). `out_rs` and `out_rt` carry bits 25:21 and 20:16. `out_rd`, `out_shamt`, `out_funct` and `out_target` are 0.
- R3: Opcodes 2 and 3 give `out_fmt` 3 (jump). `out_target` carries bits 25:0, and every register, shift, function and immediate output is 0.
- R4: For opcodes 4, 5, 8, 35 and 43, `out_imm` is bits 15:0 sign-extended to 32 bits.
- R5: For opcode 13, `out_imm` is bits 15:0 zero-extended to 32 bits.
- R6: For opcode 15, `out_imm` holds bits 15:0 in its bits 31:16, and its bits 15:0 are zero.
- R7: `out_nop` is 1 exactly when the whole word is 0x00000000. Such a word still decodes as register format with all fields zero.
- R8: Any other opcode sets `out_illegal`. It also gives `out_fmt` 0 and zero on every field output except `out_opcode`, which always carries bits 31:26.
- R9: A word presented with `in_valid` high appears on the outputs one clock later with `out_valid` high. After a cycle with `in_valid` low, `out_valid` is low and the field outputs keep their previous values.
- R10: While `rst` is high at a clock edge, `out_valid` and every field output are cleared to zero.
- R11: The word 0x012A4020 decodes to register format with rs 9, rt 10, rd 8, shamt 0 and funct 32. The word 0x22D5FFCE decodes to immediate format with rs 22, rt 21 and immediate 0xFFFFFFCE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word present this cycle |
| in_word | input | 32 | Instruction word |
| out_valid | output | 1 | Decoded fields valid |
| out_fmt | output | 2 | 0 illegal, 1 register, 2 immediate, 3 jump |
| out_illegal | output | 1 | Unsupported opcode |
| out_nop | output | 1 | Word was all zero |
| out_opcode | output | 6 | Raw opcode bits |
| out_rs | output | 5 | First source register specifier |
| out_rt | output | 5 | Second register specifier |
| out_rd | output | 5 | Destination specifier (register layout) |
| out_shamt | output | 5 | Shift amount (register layout) |
| out_funct | output | 6 | Function code (register layout) |
| out_imm | output | 32 | Extended immediate |
| out_target | output | 26 | Jump target field |

## Verification
The opcode space is swept completely. Each of the 64 opcodes is paired with several lower-bit patterns: all zeros, all ones, two alternating patterns and a few scrambled values. The all-ones and alternating patterns expose any field taken from the wrong bit position. They also show a wrong extension choice, because bit 15 takes both values across the set. A separate sweep of every function code under opcode zero confirms that the function field passes through untouched. Two known encodings, the zero word, and a word presented with `in_valid` low tell apart correct field recovery, no-op detection and the output hold.

// File: rtl/ifd_pkg.sv
package ifd_pkg;
  localparam int WORD_W = 32;
  localparam int OP_W   = 6;
  localparam int REG_W  = 5;
  localparam int SH_W   = 5;
  localparam int FN_W   = 6;
  localparam int IMM_W  = 16;
  localparam int TGT_W  = WORD_W - OP_W;

  localparam int OP_LSB = WORD_W - OP_W;
  localparam int RS_LSB = OP_LSB - REG_W;
  localparam int RT_LSB = RS_LSB - REG_W;
  localparam int RD_LSB = RT_LSB - REG_W;
  localparam int SH_LSB = RD_LSB - SH_W;

  localparam logic [OP_W-1:0] OPC_REG     = 6'd0;
  localparam logic [OP_W-1:0] OPC_JUMP    = 6'd2;
  localparam logic [OP_W-1:0] OPC_JLINK   = 6'd3;
  localparam logic [OP_W-1:0] OPC_BR_EQ   = 6'd4;
  localparam logic [OP_W-1:0] OPC_BR_NE   = 6'd5;
  localparam logic [OP_W-1:0] OPC_ADD_IMM = 6'd8;
  localparam logic [OP_W-1:0] OPC_OR_IMM  = 6'd13;
  localparam logic [OP_W-1:0] OPC_LOAD_UP = 6'd15;
  localparam logic [OP_W-1:0] OPC_LOAD    = 6'd35;
  localparam logic [OP_W-1:0] OPC_STORE   = 6'd43;

  typedef enum logic [1:0] {
    FMT_NONE = 2'd0,
    FMT_REG  = 2'd1,
    FMT_IMM  = 2'd2,
    FMT_JMP  = 2'd3
  } fmt_e;

  typedef enum logic [1:0] {
    EXT_SIGN  = 2'd0,
    EXT_ZERO  = 2'd1,
    EXT_UPPER = 2'd2
  } ext_e;

  typedef struct packed {
    fmt_e              fmt;
    logic              illegal;
    logic              nop;
    logic [OP_W-1:0]   opcode;
    logic [REG_W-1:0]  rs;
    logic [REG_W-1:0]  rt;
    logic [REG_W-1:0]  rd;
    logic [SH_W-1:0]   shamt;
    logic [FN_W-1:0]   funct;
    logic [WORD_W-1:0] imm;
    logic [TGT_W-1:0]  target;
  } dec_t;
endpackage

// File: rtl/ifd_classify.sv
module ifd_classify
  import ifd_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  output fmt_e            fmt,
  output ext_e            ext
);
  always_comb begin
    fmt = FMT_NONE;
    ext = EXT_SIGN;
    unique case (opcode)
      OPC_REG:                 fmt = FMT_REG;
      OPC_JUMP, OPC_JLINK:     fmt = FMT_JMP;
      OPC_BR_EQ, OPC_BR_NE,
      OPC_ADD_IMM, OPC_LOAD,
      OPC_STORE:               fmt = FMT_IMM;
      OPC_OR_IMM: begin
        fmt = FMT_IMM;
        ext = EXT_ZERO;
      end
      OPC_LOAD_UP: begin
        fmt = FMT_IMM;
        ext = EXT_UPPER;
      end
      default:                 fmt = FMT_NONE;
    endcase
  end
endmodule

// File: rtl/ifd_immext.sv
module ifd_immext
  import ifd_pkg::*;
#(
  parameter int IN_W  = IMM_W,
  parameter int OUT_W = WORD_W
) (
  input  logic [IN_W-1:0]  imm,
  input  ext_e             ext,
  output logic [OUT_W-1:0] wide
);
  localparam int PAD_W = OUT_W - IN_W;

  logic [OUT_W-1:0] sx, zx, up;

  assign sx = {{PAD_W{imm[IN_W-1]}}, imm};
  assign zx = {{PAD_W{1'b0}}, imm};
  assign up = zx << PAD_W;

  always_comb begin
    unique case (ext)
      EXT_ZERO:  wide = zx;
      EXT_UPPER: wide = up;
      default:   wide = sx;
    endcase
  end
endmodule

// File: rtl/ifd_fields.sv
module ifd_fields
  import ifd_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  fmt_e              fmt,
  input  logic [WORD_W-1:0] imm_wide,
  output dec_t              dec
);
  always_comb begin
    dec         = '0;
    dec.fmt     = fmt;
    dec.opcode  = word[OP_LSB +: OP_W];
    dec.illegal = (fmt == FMT_NONE);
    dec.nop     = (word == '0);
    case (fmt)
      FMT_REG: begin
        dec.rs    = word[RS_LSB +: REG_W];
        dec.rt    = word[RT_LSB +: REG_W];
        dec.rd    = word[RD_LSB +: REG_W];
        dec.shamt = word[SH_LSB +: SH_W];
        dec.funct = word[0 +: FN_W];
      end
      FMT_IMM: begin
        dec.rs  = word[RS_LSB +: REG_W];
        dec.rt  = word[RT_LSB +: REG_W];
        dec.imm = imm_wide;
      end
      FMT_JMP: dec.target = word[0 +: TGT_W];
      default: ;
    endcase
  end
endmodule

// File: rtl/ifd_outreg.sv
module ifd_outreg #(
  parameter int DW      = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] d,
  output logic          q_valid,
  output logic [DW-1:0] q
);
  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          q_valid <= 1'b0;
          q       <= '0;
        end else begin
          q_valid <= in_valid;
          if (in_valid) q <= d;
        end
      end
    end else begin : g_pass
      assign q_valid = in_valid;
      assign q       = d;
    end
  endgenerate
endmodule

// File: rtl/instr_field_decoder.sv
module instr_field_decoder
  import ifd_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  output logic [1:0]        out_fmt,
  output logic              out_illegal,
  output logic              out_nop,
  output logic [OP_W-1:0]   out_opcode,
  output logic [REG_W-1:0]  out_rs,
  output logic [REG_W-1:0]  out_rt,
  output logic [REG_W-1:0]  out_rd,
  output logic [SH_W-1:0]   out_shamt,
  output logic [FN_W-1:0]   out_funct,
  output logic [WORD_W-1:0] out_imm,
  output logic [TGT_W-1:0]  out_target
);
  localparam int DEC_W = $bits(dec_t);

  fmt_e              fmt_c;
  ext_e              ext_c;
  logic [WORD_W-1:0] imm_c;
  dec_t              dec_c;
  dec_t              dec_q;
  logic [DEC_W-1:0]  dec_q_bits;

  ifd_classify u_cls (
    .opcode (in_word[OP_LSB +: OP_W]),
    .fmt    (fmt_c),
    .ext    (ext_c)
  );

  ifd_immext #(.IN_W(IMM_W), .OUT_W(WORD_W)) u_ext (
    .imm  (in_word[0 +: IMM_W]),
    .ext  (ext_c),
    .wide (imm_c)
  );

  ifd_fields u_fld (
    .word     (in_word),
    .fmt      (fmt_c),
    .imm_wide (imm_c),
    .dec      (dec_c)
  );

  ifd_outreg #(.DW(DEC_W), .OUT_REG(OUT_REG)) u_oreg (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .d        (dec_c),
    .q_valid  (out_valid),
    .q        (dec_q_bits)
  );

  assign dec_q       = dec_t'(dec_q_bits);
  assign out_fmt     = dec_q.fmt;
  assign out_illegal = dec_q.illegal;
  assign out_nop     = dec_q.nop;
  assign out_opcode  = dec_q.opcode;
  assign out_rs      = dec_q.rs;
  assign out_rt      = dec_q.rt;
  assign out_rd      = dec_q.rd;
  assign out_shamt   = dec_q.shamt;
  assign out_funct   = dec_q.funct;
  assign out_imm     = dec_q.imm;
  assign out_target  = dec_q.target;

  generate
    if (OUT_REG) begin : g_chk
      // R9
      valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
      // R9
      valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid && $stable(out_imm) && $stable(out_rs) && $stable(out_target));
      // R1
      reg_fields_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_word[OP_LSB +: OP_W] == OPC_REG |=>
        out_rd == $past(in_word[RD_LSB +: REG_W]) && out_funct == $past(in_word[0 +: FN_W]) && out_imm == '0);
      // R3
      jump_clean_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_fmt == FMT_JMP |->
        out_rs == '0 && out_rt == '0 && out_rd == '0 && out_imm == '0 && out_funct == '0);
      // R4
      sign_ext_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_word[OP_LSB +: OP_W] == OPC_ADD_IMM |=>
        out_imm == {{(WORD_W-IMM_W){$past(in_word[IMM_W-1])}}, $past(in_word[0 +: IMM_W])});
      // R5
      zero_ext_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_word[OP_LSB +: OP_W] == OPC_OR_IMM |=>
        out_imm[WORD_W-1:IMM_W] == '0 && out_imm[IMM_W-1:0] == $past(in_word[0 +: IMM_W]));
      // R6
      upper_imm_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_word[OP_LSB +: OP_W] == OPC_LOAD_UP |=>
        out_imm[IMM_W-1:0] == '0 && out_imm[WORD_W-1:WORD_W-IMM_W] == $past(in_word[0 +: IMM_W]));
      // R7
      nop_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_word == '0 |=> out_nop && out_fmt == FMT_REG);
      // R8
      illegal_clear_chk: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> out_fmt == FMT_NONE && out_imm == '0 && out_target == '0 && out_rs == '0);
    end
  endgenerate
endmodule

// File: tb/instr_field_decoder_test.sv
`timescale 1ns/1ps
module instr_field_decoder_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_word = '0;
  logic        out_valid, out_illegal, out_nop;
  logic [1:0]  out_fmt;
  logic [5:0]  out_opcode, out_funct;
  logic [4:0]  out_rs, out_rt, out_rd, out_shamt;
  logic [31:0] out_imm;
  logic [25:0] out_target;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  instr_field_decoder uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
    .out_valid(out_valid), .out_fmt(out_fmt), .out_illegal(out_illegal),
    .out_nop(out_nop), .out_opcode(out_opcode), .out_rs(out_rs),
    .out_rt(out_rt), .out_rd(out_rd), .out_shamt(out_shamt),
    .out_funct(out_funct), .out_imm(out_imm), .out_target(out_target)
  );

  function automatic logic [93:0] got_vec();
    return {out_fmt, out_illegal, out_nop, out_opcode, out_rs, out_rt, out_rd,
            out_shamt, out_funct, out_imm, out_target};
  endfunction

  // Expected outputs from the requirements: fmt,illegal,nop,opcode,rs,rt,rd,shamt,funct,imm,target
  function automatic logic [93:0] model(input logic [31:0] w);
    logic [5:0]  op;
    logic [1:0]  f;
    logic [31:0] im;
    logic [4:0]  rs, rt, rd, sh;
    logic [5:0]  fn;
    logic [25:0] tg;
    op = w[31:26];
    f = 2'd0; im = '0; rs = '0; rt = '0; rd = '0; sh = '0; fn = '0; tg = '0;
    if (op == 6'd0) begin
      f = 2'd1; rs = w[25:21]; rt = w[20:16]; rd = w[15:11]; sh = w[10:6]; fn = w[5:0];
    end else if (op == 6'd2 || op == 6'd3) begin
      f = 2'd3; tg = w[25:0];
    end else if (op == 6'd4 || op == 6'd5 || op == 6'd8 || op == 6'd35 || op == 6'd43) begin
      f = 2'd2; rs = w[25:21]; rt = w[20:16];
      im = $unsigned(32'($signed(w[15:0])));
    end else if (op == 6'd13) begin
      f = 2'd2; rs = w[25:21]; rt = w[20:16]; im = 32'(w[15:0]);
    end else if (op == 6'd15) begin
      f = 2'd2; rs = w[25:21]; rt = w[20:16]; im = 32'(w[15:0]) * 32'd65536;
    end
    return {f, (f == 2'd0), (w == 32'd0), op, rs, rt, rd, sh, fn, im, tg};
  endfunction

  function automatic string tag_of(input logic [31:0] w);
    logic [5:0] op;
    op = w[31:26];
    if (w == 32'd0) return "R7";
    if (op == 6'd0) return "R1";
    if (op == 6'd2 || op == 6'd3) return "R3";
    if (op == 6'd13) return "R5";
    if (op == 6'd15) return "R6";
    if (op == 6'd4 || op == 6'd5 || op == 6'd8 || op == 6'd35 || op == 6'd43) return "R4/R2";
    return "R8";
  endfunction

  task automatic check(input string tag, input logic ok, input logic [93:0] act, input logic [93:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] w, input logic [93:0] exp, input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    @(negedge clk);
    in_valid = 1'b0;
    check(tag, out_valid === 1'b1 && got_vec() === exp, {out_valid, got_vec()}, {1'b1, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [25:0] pat;
    logic [31:0] hold_w;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    check("R10", out_valid === 1'b0 && got_vec() === '0, {out_valid, got_vec()}, '0);

    // R11: known encodings, hand-derived expectations
    apply(32'h012A4020, {2'd1, 1'b0, 1'b0, 6'd0, 5'd9, 5'd10, 5'd8, 5'd0, 6'd32, 32'd0, 26'd0}, "R11");
    apply(32'h22D5FFCE, {2'd2, 1'b0, 1'b0, 6'd8, 5'd22, 5'd21, 5'd0, 5'd0, 6'd0, 32'hFFFFFFCE, 26'd0}, "R11");

    // R7: zero word is a no-op in register format
    apply(32'd0, {2'd1, 1'b0, 1'b1, 6'd0, 5'd0, 5'd0, 5'd0, 5'd0, 6'd0, 32'd0, 26'd0}, "R7");

    // R1 R2 R3 R4 R5 R6 R8: every opcode with several lower-bit patterns
    for (int op = 0; op < 64; op++) begin
      for (int k = 0; k < 8; k++) begin
        case (k)
          0: pat = 26'h0000000;
          1: pat = 26'h3FFFFFF;
          2: pat = 26'h2AAAAAA;
          3: pat = 26'h1555555;
          default: pat = 26'((op * 32'h9E3779B1) ^ (k * 32'h7F4A7C15));
        endcase
        apply({6'(op), pat}, model({6'(op), pat}), tag_of({6'(op), pat}));
      end
    end

    // R1: every function code under opcode zero
    for (int fn = 0; fn < 64; fn++) begin
      hold_w = {6'd0, 5'd17, 5'd3, 5'd30, 5'd12, 6'(fn)};
      apply(hold_w, model(hold_w), "R1");
    end

    // R9: outputs hold and valid drops when in_valid is low
    hold_w = 32'h3C01ABCD;
    apply(hold_w, model(hold_w), "R6");
    @(negedge clk);
    in_word = 32'h08000123;
    @(negedge clk);
    check("R9", out_valid === 1'b0 && got_vec() === model(hold_w),
          {out_valid, got_vec()}, {1'b0, model(hold_w)});

    // R10: reset mid-stream clears outputs
    apply(32'h8C2AFFF0, model(32'h8C2AFFF0), "R4");
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R10", out_valid === 1'b0 && got_vec() === '0, {out_valid, got_vec()}, '0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule